// File: doc/BRIEF.md
# Block Transfer Address Sequencer

The block turns one multi-register memory transfer request into a stream of single-word transfers, one per clock cycle. A request carries a base address, a 16-bit bitmap that selects the registers to move, a direction flag (load from memory or store to memory), an address direction (up or down), a pre/post stepping choice and a writeback enable. The block accepts the request on a start pulse and is busy while it issues the transfers. For each transfer it presents a register index, a word address and a write strobe. The memory and the register file sit outside the block.

Registers always occupy ascending word addresses in ascending index order, whatever the address direction. The direction and the pre/post choice only decide where that window of addresses lies relative to the base. Seen as stack accesses, a downward-growing stack whose pointer addresses the last used word is a store with down/pre stepping and a load with up/post stepping. An upward-growing stack of the same kind is a store with up/pre stepping and a load with down/post stepping. When the transfers are complete, the block pulses done. At that point it presents the updated base. It also reports whether register 15 was loaded, since such a load redirects program flow.

Top module: `blockxfer_seq`

## Requirements
- R1: A start pulse is accepted when the block is not busy. Busy is high from the cycle after acceptance until the last transfer. A start while busy is ignored: the running sequence is not altered and no new one follows it.
- R2: With N bits set in the bitmap, xferValid is high for exactly N consecutive cycles, starting the cycle after acceptance. xferReg gives the selected register numbers in strictly ascending order, and each address is 4 above the previous one.
- R3: Up/post mode (upMode=1, preStep=0): the first address is the aligned base.
- R4: Up/pre mode (upMode=1, preStep=1): the first address is the aligned base + 4.
- R5: Down/post mode (upMode=0, preStep=0): the last address is the aligned base, so the first address is base − 4N + 4.
- R6: Down/pre mode (upMode=0, preStep=1): the last address is the aligned base − 4, so the first address is base − 4N.
- R7: done is a one-cycle pulse in the cycle right after the last transfer. busy is low while done is high, and done is low in the following cycle unless a new request is running.
- R8: An empty bitmap gives done in the cycle after acceptance, with no cycle of xferValid.
- R9: In the done cycle, newBase equals the aligned base + 4N (up modes) or − 4N (down modes). wbValid is high in that cycle exactly when writeback was requested.
- R10: pcLoaded is high in the done cycle exactly when the request was a load whose bitmap has bit 15 set. It is low for stores.
- R11: xferWrite is high during every transfer of a store (isLoad=0) and low during every transfer of a load.
- R12: Every address is word-aligned. The two low bits of the base are discarded, so bits [1:0] of xferAddr and of newBase are always 0.
- R13: A start accepted in the done cycle begins the next sequence at once, with its first transfer in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken when not busy |
| baseAddr | input | 32 | Base address of the request |
| regMask | input | 16 | Bitmap of registers to transfer |
| isLoad | input | 1 | 1 = memory to registers, 0 = registers to memory |
| upMode | input | 1 | 1 = addresses above base, 0 = below |
| preStep | input | 1 | 1 = step before each transfer, 0 = after |
| wbEn | input | 1 | Request writeback of the updated base |
| busy | output | 1 | Transfers in progress |
| done | output | 1 | One-cycle completion pulse |
| xferValid | output | 1 | A word transfer is presented this cycle |
| xferReg | output | 4 | Register number of the current transfer |
| xferAddr | output | 32 | Word address of the current transfer |
| xferWrite | output | 1 | Current transfer writes memory |
| newBase | output | 32 | Updated base, valid in the done cycle |
| wbValid | output | 1 | Writeback of newBase requested, with done |
| pcLoaded | output | 1 | Register 15 was loaded, with done |

## Verification
Two functions can fall in the same cycle: the completion pulse of one request and the acceptance of the next. The bench raises start in the very cycle where done is observed for a run. It judges the overlap by checking that done was still reported correctly for the first request, including newBase, and that the second request's first transfer appears in the next cycle at its own start address. A second overlap is a start arriving mid-run. For that case the bench checks that the running addresses stay on their original path and that busy stays low after done.

// File: rtl/blockxfer_pkg.sv
package blockxfer_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_RUN  = 2'd1,
    SEQ_DONE = 2'd2
  } seqState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;  // latch a new request
    logic advance;  // retire the current transfer
  } seqStrobes_t;

endpackage

// File: rtl/blockxfer_ctrl.sv
module blockxfer_ctrl
  import blockxfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic        reqEmpty,
  input  logic        lastXfer,
  output seqStrobes_t strobes,
  output logic        inRun,
  output logic        inDone
);

  seqState_t state, stateNext;

  always_comb begin
    strobes.capture = start && (state != SEQ_RUN);
    strobes.advance = (state == SEQ_RUN);
    stateNext = state;
    case (state)
      SEQ_IDLE: begin
        if (strobes.capture) stateNext = reqEmpty ? SEQ_DONE : SEQ_RUN;
      end
      SEQ_RUN: begin
        if (lastXfer) stateNext = SEQ_DONE;
      end
      SEQ_DONE: begin
        if (strobes.capture) stateNext = reqEmpty ? SEQ_DONE : SEQ_RUN;
        else                 stateNext = SEQ_IDLE;
      end
      default: stateNext = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= stateNext;
  end

  assign inRun  = (state == SEQ_RUN);
  assign inDone = (state == SEQ_DONE);

endmodule

// File: rtl/blockxfer_path.sv
module blockxfer_path
  import blockxfer_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int NUM_REGS   = 16,
  parameter int WORD_BYTES = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  seqStrobes_t                 strobes,
  input  logic [ADDR_W-1:0]           baseAddr,
  input  logic [NUM_REGS-1:0]         regMask,
  input  logic                        isLoad,
  input  logic                        upMode,
  input  logic                        preStep,
  input  logic                        wbEn,
  output logic                        reqEmpty,
  output logic                        lastXfer,
  output logic [$clog2(NUM_REGS)-1:0] curReg,
  output logic [ADDR_W-1:0]           curAddr,
  output logic [ADDR_W-1:0]           finalBase,
  output logic                        loadDir,
  output logic                        wbReq,
  output logic                        pcHit
);

  localparam int IDX_W  = $clog2(NUM_REGS);
  localparam int CNT_W  = $clog2(NUM_REGS + 1);
  localparam int BYTE_SH = $clog2(WORD_BYTES);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);
  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(WORD_BYTES - 1);

  function automatic logic [CNT_W-1:0] countOnes(input logic [NUM_REGS-1:0] m);
    logic [CNT_W-1:0] c;
    c = '0;
    for (int i = 0; i < NUM_REGS; i++) c = c + CNT_W'(m[i]);
    return c;
  endfunction

  function automatic logic [IDX_W-1:0] lowestIdx(input logic [NUM_REGS-1:0] m);
    logic [IDX_W-1:0] idx;
    idx = '0;
    for (int i = NUM_REGS - 1; i >= 0; i--) begin
      if (m[i]) idx = IDX_W'(i);
    end
    return idx;
  endfunction

  logic [NUM_REGS-1:0] remMask;
  logic [ADDR_W-1:0]   addrReg;
  logic [ADDR_W-1:0]   baseOut;
  logic                loadReg, wbReg, pcReg;

  // Request decode
  logic [CNT_W-1:0]  reqCount;
  logic [ADDR_W-1:0] alignedBase, span, firstAddr, endBase;
  logic [NUM_REGS-1:0] lowBit;

  always_comb begin
    reqCount    = countOnes(regMask);
    alignedBase = baseAddr & ALIGN_MASK;
    span        = {{(ADDR_W-CNT_W){1'b0}}, reqCount} << BYTE_SH;
    case ({upMode, preStep})
      2'b10:   firstAddr = alignedBase;
      2'b11:   firstAddr = alignedBase + STEP;
      2'b00:   firstAddr = alignedBase - span + STEP;
      default: firstAddr = alignedBase - span;
    endcase
    endBase = upMode ? (alignedBase + span) : (alignedBase - span);
    lowBit  = remMask & (~remMask + NUM_REGS'(1));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      remMask <= '0;
      addrReg <= '0;
      baseOut <= '0;
      loadReg <= 1'b0;
      wbReg   <= 1'b0;
      pcReg   <= 1'b0;
    end else if (strobes.capture) begin
      remMask <= regMask;
      addrReg <= firstAddr;
      baseOut <= endBase;
      loadReg <= isLoad;
      wbReg   <= wbEn;
      pcReg   <= isLoad && regMask[NUM_REGS-1];
    end else if (strobes.advance) begin
      remMask <= remMask & ~lowBit;
      addrReg <= addrReg + STEP;
    end
  end

  assign reqEmpty  = (regMask == '0);
  assign lastXfer  = ((remMask & (remMask - NUM_REGS'(1))) == '0);
  assign curReg    = lowestIdx(remMask);
  assign curAddr   = addrReg;
  assign finalBase = baseOut;
  assign loadDir   = loadReg;
  assign wbReq     = wbReg;
  assign pcHit     = pcReg;

endmodule

// File: rtl/blockxfer_seq.sv
module blockxfer_seq
  import blockxfer_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  input  logic [31:0] baseAddr,
  input  logic [15:0] regMask,
  input  logic        isLoad,
  input  logic        upMode,
  input  logic        preStep,
  input  logic        wbEn,
  output logic        busy,
  output logic        done,
  output logic        xferValid,
  output logic [3:0]  xferReg,
  output logic [31:0] xferAddr,
  output logic        xferWrite,
  output logic [31:0] newBase,
  output logic        wbValid,
  output logic        pcLoaded
);

  seqStrobes_t strobes;
  logic reqEmpty, lastXfer, inRun, inDone, loadDir, wbReq, pcHit;
  logic [3:0]  curReg;
  logic [31:0] curAddr, finalBase;

  blockxfer_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .reqEmpty (reqEmpty),
    .lastXfer (lastXfer),
    .strobes  (strobes),
    .inRun    (inRun),
    .inDone   (inDone)
  );

  blockxfer_path #(
    .ADDR_W     (32),
    .NUM_REGS   (16),
    .WORD_BYTES (4)
  ) u_path (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .baseAddr  (baseAddr),
    .regMask   (regMask),
    .isLoad    (isLoad),
    .upMode    (upMode),
    .preStep   (preStep),
    .wbEn      (wbEn),
    .reqEmpty  (reqEmpty),
    .lastXfer  (lastXfer),
    .curReg    (curReg),
    .curAddr   (curAddr),
    .finalBase (finalBase),
    .loadDir   (loadDir),
    .wbReq     (wbReq),
    .pcHit     (pcHit)
  );

  assign busy      = inRun;
  assign done      = inDone;
  assign xferValid = inRun;
  assign xferReg   = curReg;
  assign xferAddr  = curAddr;
  assign xferWrite = inRun && !loadDir;
  assign newBase   = finalBase;
  assign wbValid   = inDone && wbReq;
  assign pcLoaded  = inDone && pcHit;

endmodule

// File: rtl/blockxfer_chk.sv
module blockxfer_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busy,
  input logic        done,
  input logic        xferValid,
  input logic [3:0]  xferReg,
  input logic [31:0] xferAddr,
  input logic        xferWrite,
  input logic [31:0] newBase,
  input logic        wbValid,
  input logic        pcLoaded
);

  // R2
  reg_ascending_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && $past(xferValid)) |-> (xferReg > $past(xferReg)));

  // R2
  addr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (xferValid && $past(xferValid)) |-> (xferAddr == $past(xferAddr) + 32'd4));

  // R12
  addr_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    xferValid |-> (xferAddr[1:0] == 2'b00));

  // R12
  base_aligned_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (newBase[1:0] == 2'b00));

  // R7
  done_not_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  // R7
  done_after_run_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(busy) && !busy) |-> done);

  // R9
  wb_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    wbValid |-> done);

  // R10
  pc_with_done_chk: assert property (@(posedge clk) disable iff (!rstN)
    pcLoaded |-> done);

  // R11
  write_steady_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(xferWrite));

endmodule

bind blockxfer_seq blockxfer_chk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busy      (busy),
  .done      (done),
  .xferValid (xferValid),
  .xferReg   (xferReg),
  .xferAddr  (xferAddr),
  .xferWrite (xferWrite),
  .newBase   (newBase),
  .wbValid   (wbValid),
  .pcLoaded  (pcLoaded)
);

// File: tb/tb_blockxfer_seq.sv
`timescale 1ns/1ps
module tb_blockxfer_seq;

  logic        clk = 1'b0;
  logic        rstN;
  logic        start;
  logic [31:0] baseAddr;
  logic [15:0] regMask;
  logic        isLoad, upMode, preStep, wbEn;
  logic        busy, done, xferValid, xferWrite, wbValid, pcLoaded;
  logic [3:0]  xferReg;
  logic [31:0] xferAddr, newBase;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #10 clk = ~clk;  // 50 MHz

  blockxfer_seq dut (
    .clk(clk), .rstN(rstN), .start(start), .baseAddr(baseAddr),
    .regMask(regMask), .isLoad(isLoad), .upMode(upMode), .preStep(preStep),
    .wbEn(wbEn), .busy(busy), .done(done), .xferValid(xferValid),
    .xferReg(xferReg), .xferAddr(xferAddr), .xferWrite(xferWrite),
    .newBase(newBase), .wbValid(wbValid), .pcLoaded(pcLoaded)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog act=%0d exp=<20000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  // Drive a request now (at a negedge), drop start at the next negedge.
  task automatic launch(input logic [31:0] b, input logic [15:0] m,
                        input logic ld, input logic up, input logic pre,
                        input logic wb);
    baseAddr = b; regMask = m; isLoad = ld; upMode = up; preStep = pre; wbEn = wb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  // Sample a running request from the first transfer cycle through done.
  // Returns at the done negedge. junk=1 pulses a start mid-run.
  task automatic checkRun(input logic [31:0] b, input logic [15:0] m,
                          input logic ld, input logic up, input logic pre,
                          input logic wb, input bit junk);
    int n = 0;
    logic [31:0] ab, expAddr, expBase;
    string modeReq;
    int nextReg = 0;
    for (int i = 0; i < 16; i++) if (m[i]) n++;
    ab = {b[31:2], 2'b00};
    case ({up, pre})
      2'b10:   begin expAddr = ab;                       modeReq = "R3"; end
      2'b11:   begin expAddr = ab + 32'd4;               modeReq = "R4"; end
      2'b00:   begin expAddr = ab - 32'(4*n) + 32'd4;    modeReq = "R5"; end
      default: begin expAddr = ab - 32'(4*n);            modeReq = "R6"; end
    endcase
    expBase = up ? ab + 32'(4*n) : ab - 32'(4*n);
    for (int k = 0; k < n; k++) begin
      while (!m[nextReg]) nextReg++;
      chk(xferValid === 1'b1, "R2", "xferValid", 32'(xferValid), 32'd1);
      chk(busy === 1'b1, "R1", "busy", 32'(busy), 32'd1);
      chk(xferReg === 4'(nextReg), "R2", "xferReg", 32'(xferReg), 32'(nextReg));
      chk(xferAddr === expAddr, (k == 0) ? modeReq : "R2", "xferAddr", xferAddr, expAddr);
      chk(xferAddr[1:0] === 2'b00, "R12", "addr low bits", 32'(xferAddr[1:0]), 32'd0);
      chk(xferWrite === !ld, "R11", "xferWrite", 32'(xferWrite), 32'(!ld));
      chk(done === 1'b0, "R7", "done early", 32'(done), 32'd0);
      nextReg++;
      expAddr = expAddr + 32'd4;
      if (junk && k == 1) begin
        start = 1'b1; baseAddr = 32'hDEAD0000; regMask = 16'h0001;
      end
      @(negedge clk);
      if (junk && k == 1) start = 1'b0;
    end
    chk(done === 1'b1, (n == 0) ? "R8" : "R7", "done", 32'(done), 32'd1);
    chk(busy === 1'b0, "R7", "busy at done", 32'(busy), 32'd0);
    chk(xferValid === 1'b0, (n == 0) ? "R8" : "R2", "xferValid at done", 32'(xferValid), 32'd0);
    chk(newBase === expBase, "R9", "newBase", newBase, expBase);
    chk(wbValid === wb, "R9", "wbValid", 32'(wbValid), 32'(wb));
    chk(pcLoaded === (ld & m[15]), "R10", "pcLoaded", 32'(pcLoaded), 32'(ld & m[15]));
  endtask

  task automatic expectIdle(input string req);
    @(negedge clk);
    chk(done === 1'b0, req, "done after pulse", 32'(done), 32'd0);
    chk(busy === 1'b0, req, "busy after done", 32'(busy), 32'd0);
    chk(xferValid === 1'b0, req, "xferValid idle", 32'(xferValid), 32'd0);
  endtask

  task automatic runOne(input logic [31:0] b, input logic [15:0] m,
                        input logic ld, input logic up, input logic pre,
                        input logic wb);
    @(negedge clk);
    launch(b, m, ld, up, pre, wb);
    checkRun(b, m, ld, up, pre, wb, 1'b0);
    expectIdle("R7");
  endtask

  task automatic testReset();
    chk(busy === 1'b0, "R1", "reset busy", 32'(busy), 32'd0);
    chk(done === 1'b0, "R7", "reset done", 32'(done), 32'd0);
    chk(xferValid === 1'b0, "R2", "reset xferValid", 32'(xferValid), 32'd0);
  endtask

  task automatic testStartIgnored();
    // R1: start pulse mid-run must not alter or extend the sequence
    @(negedge clk);
    launch(32'h0000_3000, 16'h00F0, 1'b0, 1'b1, 1'b0, 1'b1);
    checkRun(32'h0000_3000, 16'h00F0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1);
    expectIdle("R1");
  endtask

  task automatic testBackToBack();
    // R13: next start given in the done cycle of the previous request
    @(negedge clk);
    launch(32'h0000_4000, 16'h0006, 1'b1, 1'b1, 1'b1, 1'b1);
    checkRun(32'h0000_4000, 16'h0006, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
    launch(32'h0000_5000, 16'h8001, 1'b1, 1'b0, 1'b0, 1'b0);
    chk(busy === 1'b1, "R13", "busy after chained start", 32'(busy), 32'd1);
    checkRun(32'h0000_5000, 16'h8001, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
    expectIdle("R13");
  endtask

  initial begin
    rstN = 1'b0; start = 1'b0; baseAddr = '0; regMask = '0;
    isLoad = 1'b0; upMode = 1'b0; preStep = 1'b0; wbEn = 1'b0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    testReset();
    // R3: up/post, three registers from 0x1000, writeback 0x100C
    runOne(32'h0000_1000, 16'h0013, 1'b1, 1'b1, 1'b0, 1'b1);
    // R4: up/pre store, upward-growing full stack push
    runOne(32'h0000_2000, 16'h4009, 1'b0, 1'b1, 1'b1, 1'b1);
    // R5, R10: down/post load including register 15
    runOne(32'h0000_1000, 16'h8005, 1'b1, 1'b0, 1'b0, 1'b1);
    // R6, R10: down/pre store including register 15, no pc flag
    runOne(32'h0000_1000, 16'h8005, 1'b0, 1'b0, 1'b1, 1'b0);
    // R6, R2: all sixteen registers loaded, down/pre
    runOne(32'h0000_2000, 16'hFFFF, 1'b1, 1'b0, 1'b1, 1'b1);
    // R8: empty bitmap
    runOne(32'h0000_0800, 16'h0000, 1'b1, 1'b1, 1'b0, 1'b1);
    // R12: unaligned base
    runOne(32'h0000_1003, 16'h0102, 1'b0, 1'b1, 1'b0, 1'b1);
    testStartIgnored();
    testBackToBack();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule